// File: doc/BRIEF.md
# Latched 1-of-16 Decoder / Demultiplexer

This block turns a 4-bit binary code into one of sixteen active-high select lines. The code first passes through a level-sensitive address holder. While the hold-open input is high, the holder is transparent and the decoded line follows the live code. When that input drops, the code present at that moment is kept, and the outputs no longer respond to the code pins.

An active-low output enable gates all sixteen lines. It does not disturb the held code. The block also serves as a 1-to-16 demultiplexer. The code picks the destination line and the serial data drives the enable pin. The selected line then carries the inverse of the data bit, and every other line stays low.

A parameter picks how the holder is built. The default is a true level-sensitive latch. The alternative is a clocked register that samples the code on each rising clock edge while the hold-open input is high, which suits fabrics without latches. An active-low reset clears the held code to zero.

Top module: `latched_decoder`

## Requirements
- R1: While `rst_n` is low, the held code is forced to 0. After release with `hold_open_i` low, code 0 remains held, so with `out_en_n` low the output is `16'h0001`.
- R2: With `hold_open_i` high and `out_en_n` low, `sel_o` equals `1 << addr_i` for each of the 16 code values, following the live `addr_i`.
- R3: Once `hold_open_i` falls, the code on `addr_i` at that moment is held. Later changes on `addr_i` while `hold_open_i` stays low leave `sel_o` unchanged.
- R4: With `out_en_n` high, all sixteen bits of `sel_o` are 0, whatever the code and whatever the holder state.
- R5: Toggling `out_en_n` while the holder is closed does not alter the held code. When the enable returns low, the same output index is high again.
- R6: In demultiplexer use (holder open, code fixed), `sel_o[addr_i]` equals the inverse of `out_en_n` and all other bits are 0.
- R7: `sel_o` never has more than one bit high.
- R8: `addr_i[0]` is the least significant code bit. Code value k selects `sel_o[k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; used by the register variant of the holder and by the checks |
| rst_n | input | 1 | Active-low reset; clears the held code to 0 |
| addr_i | input | 4 | Binary code, bit 0 least significant |
| hold_open_i | input | 1 | High: holder transparent; low: holder keeps its code |
| out_en_n | input | 1 | Active-low output enable; also serves as the demultiplexer data input |
| sel_o | output | 16 | Decoded select lines, active high, at most one set |

## Verification
A corrupted held code shows at the ports as the wrong select line, as soon as the output enable is low. With the latch variant there is no delay at all, since the decoder and gate are combinational. A holder that leaks while closed shows as the select line moving with the code pins during the hold phase. The bench therefore changes the code on every cycle of that phase and compares each time. A decoder fault shows as a wrong or doubled bit on the very code that hits it, which is why all sixteen codes are swept.

// File: rtl/latdec_pkg.sv
// Package: shared choices for the latched decoder.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package latdec_pkg;

    // How the address holder is realised.
    typedef enum logic {
        HOLD_LATCH = 1'b0,   // level-sensitive latch, transparent while open
        HOLD_FLOP  = 1'b1    // edge register, loads on clk while open
    } hold_style_e;

endpackage

// File: rtl/latdec_addr_hold.sv
// Module: latdec_addr_hold
// Keeps the binary code. In latch style it is transparent while le is high;
// in register style it loads on each rising clk while le is high.
// Assumes: rst_n is active low; in latch style the reset is level-acting.
module latdec_addr_hold
    import latdec_pkg::*;
#(
    parameter int          ADDR_W = 4,
    parameter hold_style_e STYLE  = HOLD_LATCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_q
);

    generate
        if (STYLE == HOLD_LATCH) begin : g_latch
            // Transparent latch with level reset.
            always_latch begin
                if (!rst_n) begin
                    addr_q = '0;
                end else if (le) begin
                    addr_q = addr_i;
                end
            end
        end else begin : g_flop
            // Clocked register with synchronous reset and load enable.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr_q <= '0;
                end else if (le) begin
                    addr_q <= addr_i;
                end
            end
        end
    endgenerate

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !$past(le)) |-> $stable(addr_q)); // R3

endmodule

// File: rtl/latdec_onehot.sv
// Module: latdec_onehot
// Full binary-to-one-hot decoder: bit k is set when code equals k.
// Assumes: NUM_OUT == 2**ADDR_W.
module latdec_onehot #(
    parameter int ADDR_W  = 4,
    parameter int NUM_OUT = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0]  code_i,
    output logic [NUM_OUT-1:0] hot_o
);

    genvar k;
    generate
        for (k = 0; k < NUM_OUT; k++) begin : g_line
            localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(k);
            // One comparator per output line.
            assign hot_o[k] = (code_i == MATCH);
        end
    endgenerate

endmodule

// File: rtl/latdec_gate.sv
// Module: latdec_gate
// Clears every decoded line while the active-low enable is high.
// Assumes: hot_i is one-hot or zero.
module latdec_gate #(
    parameter int NUM_OUT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OUT-1:0] hot_i,
    input  logic               en_n,
    output logic [NUM_OUT-1:0] sel_o
);

    // Output gating: the enable replicated across all lines.
    assign sel_o = hot_i & {NUM_OUT{~en_n}};

    AST_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o)); // R7

endmodule

// File: rtl/latched_decoder.sv
// Module: latched_decoder (top)
// Address holder -> one-hot decoder -> enable gate.
// Assumes: NUM_OUT follows from ADDR_W; HOLD_STYLE picks latch or register.
module latched_decoder
    import latdec_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter hold_style_e HOLD_STYLE = HOLD_LATCH,
    localparam int         NUM_OUT    = 1 << ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               hold_open_i,
    input  logic               out_en_n,
    output logic [NUM_OUT-1:0] sel_o
);

    logic [ADDR_W-1:0]  held_code;
    logic [NUM_OUT-1:0] hot_lines;

    latdec_addr_hold #(.ADDR_W(ADDR_W), .STYLE(HOLD_STYLE)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .le     (hold_open_i),
        .addr_i (addr_i),
        .addr_q (held_code)
    );

    latdec_onehot #(.ADDR_W(ADDR_W), .NUM_OUT(NUM_OUT)) u_dec (
        .code_i (held_code),
        .hot_o  (hot_lines)
    );

    latdec_gate #(.NUM_OUT(NUM_OUT)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .hot_i (hot_lines),
        .en_n  (out_en_n),
        .sel_o (sel_o)
    );

    AST_DISABLED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> (sel_o == '0)); // R4

    AST_ENABLED_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_n |-> ($countones(sel_o) == 1)); // R6

endmodule

// File: tb/latched_decoder_bench.sv
module latched_decoder_bench;

    localparam int AW = 4;
    localparam int NO = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_i;
    logic          hold_open_i;
    logic          out_en_n;
    logic [NO-1:0] sel_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    latched_decoder u_latched_decoder (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .hold_open_i(hold_open_i), .out_en_n(out_en_n), .sel_o(sel_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [NO-1:0] got, input logic [NO-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: sel_o=%h expected=%h", req, got, exp);
        end
    endtask

    // Move inputs just after a falling edge, then let logic settle.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; hold_open_i = 1'b0; out_en_n = 1'b0; addr_i = 4'd5;
        repeat (3) step();
        #2 chk("R1 in reset", sel_o, 16'h0001);
        rst_n = 1'b1;
        step(); addr_i = 4'd11;
        #2 chk("R1 after release", sel_o, 16'h0001);
    endtask

    task automatic t_codes();
        out_en_n = 1'b0; hold_open_i = 1'b1;
        for (int a = 0; a < NO; a++) begin
            step(); addr_i = AW'(a);
            #2 chk("R2/R8 code sweep", sel_o, NO'(1) << a);
            chk("R7 at most one", 16'($countones(sel_o) > 1), 16'h0);
        end
    endtask

    task automatic t_hold();
        step(); hold_open_i = 1'b1; addr_i = 4'd9; out_en_n = 1'b0;
        step(); hold_open_i = 1'b0;
        for (int c = 0; c < 6; c++) begin
            step(); addr_i = AW'(c * 3 + 1); out_en_n = c[0];
            #2 chk(c[0] ? "R4 closed, disabled" : "R3 held code", sel_o,
                   c[0] ? 16'h0 : 16'h0200);
        end
        step(); out_en_n = 1'b0;
        #2 chk("R5 enable toggling kept code", sel_o, 16'h0200);
        step(); hold_open_i = 1'b1; addr_i = 4'd14;
        #2 chk("R2 reopen follows", sel_o, 16'h4000);
    endtask

    task automatic t_gate();
        out_en_n = 1'b1; hold_open_i = 1'b1;
        for (int a = 0; a < NO; a += 5) begin
            step(); addr_i = AW'(a);
            #2 chk("R4 disabled dark", sel_o, 16'h0);
        end
        step(); out_en_n = 1'b0;
        #2 chk("R4 re-enable", sel_o, 16'h8000);
    endtask

    task automatic t_demux();
        logic [7:0] pattern = 8'b1011_0010;
        step(); hold_open_i = 1'b1; addr_i = 4'd6;
        for (int b = 0; b < 8; b++) begin
            step(); out_en_n = pattern[b];
            #2 chk("R6 demux data", sel_o, pattern[b] ? 16'h0 : 16'h0040);
        end
    endtask

    initial begin
        t_reset();
        t_codes();
        t_hold();
        t_gate();
        t_demux();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule